// File: doc/BRIEF.md
# Board Interrupt and Control Register Bank

This block is a memory-mapped bank of board-control registers on a simple 32-bit register bus with a single-cycle write strobe and a registered read port. It holds eight plain storage registers for LED data, LED control, switch settings and miscellaneous settings. It also holds an interrupt aggregator for sixteen level-sensitive external inputs, and two card-socket registers.

The aggregator has two registers. An enable register selects which inputs may latch. A sticky status register records every enabled input that was seen high. One host interrupt line is raised whenever any status bit is set and its enable bit is also set. Software clears or sets status bits by writing the status register, and the new value replaces the old contents.

Each card-socket register has a low power/reset field that software may write. Above that field, each register carries an active-low card-detect bit, which follows one of the interrupt inputs, and a ready bit. Software cannot change either of these upper bits. All interrupt inputs pass through a two-flop synchronizer before any use.

Top module: `brdIrqCtrl`

## Requirements
- R1: After reset, both card-socket registers read 0x00000420 (ready bit 10 and card-detect bit 5 set), every other register reads zero, and `hostIrq` is low.
- R2: Writes to offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 store all 32 bits, and a read of the same offset returns them.
- R3: While an input is high and its enable bit is set, its status bit (status offset 0xD0, bit n for input n) becomes set. The bit stays set after the input falls, until software writes the status register.
- R4: A write to the enable register (offset 0xC0) or the status register stores the written value ANDed with 0x000FEEFF. As a result, inputs 8 and 12 can never latch into status.
- R5: A write to the status register replaces its whole contents, so that one write can both set and clear bits.
- R6: `hostIrq` is high exactly when (status AND enable) is nonzero, and it reflects a write to either register from the clock edge that performs the write.
- R7: Card-detect bit 5 of socket 0 (offset 0xE0) reads 0 while input 9 is high and 1 while it is low. Bit 5 of socket 1 (offset 0xE4) follows input 13 in the same way.
- R8: A write to a card-socket register changes only its bits 4:0. All higher bits keep their values.
- R9: Read data appears on `rdData` in the cycle after the cycle in which `rdEn` is sampled high. In any cycle that follows one without `rdEn`, `rdData` is zero.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register.
- R11: An input that rises before clock edge k is seen in status and card-detect after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqIn | input | 16 | Asynchronous level-sensitive interrupt inputs |
| hostIrq | output | 1 | Aggregated interrupt to the host |

## Verification
The bench builds the block with its default parameters: sixteen inputs, a two-stage synchronizer, card-detect sources on inputs 9 and 13, and the 0xFEEFF keep pattern. With the keep pattern, the permanently masked inputs 8 and 12 can be raised while every enable bit is set and shown never to reach status. With the two-stage synchronizer, the exact edge at which an input becomes visible can be pinned down in the cycle count. Because input 13 is both an enabled interrupt and a card-detect source, one stimulus exercises status latching and the socket register together.

// File: rtl/brdIrqPkg.sv
package brdIrqPkg;

  localparam int NUM_REGS  = 12;
  localparam int NUM_PLAIN = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    REG_LED0, REG_LED1, REG_LEDCTL, REG_SWITCH,
    REG_MISC0, REG_MISC1, REG_MISC2, REG_MISCIN,
    REG_IRQEN, REG_IRQST, REG_CARD0, REG_CARD1
  } regIdxE;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHit;
    logic                rdHit;
    regIdxE              rdIdx;
  } busStrobeT;

  function automatic logic [7:0] regOffset(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      7:       return 8'h90;
      8:       return 8'hC0;
      9:       return 8'hD0;
      10:      return 8'hE0;
      default: return 8'hE4;
    endcase
  endfunction

endpackage

// File: rtl/brdIrqSync.sv
module brdIrqSync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/brdIrqCtl.sv
module brdIrqCtl
  import brdIrqPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobeT         strobe
);
  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(regOffset(i))) begin
        strobe.wrHit[i] = wrEn;
        strobe.rdHit    = rdEn;
        strobe.rdIdx    = regIdxE'(i);
      end
    end
  end
endmodule

// File: rtl/brdIrqDp.sv
module brdIrqDp
  import brdIrqPkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               NUM_IRQ     = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [31:0]      IRQ_KEEP    = 32'h000F_EEFF,
  parameter int               CARD0_IRQ   = 9,
  parameter int               CARD1_IRQ   = 13,
  parameter int               CARD_WR_W   = 5,
  parameter int               CD_BIT      = 5,
  parameter int               READY_BIT   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobeT          strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  statusQ,
  output logic [DATA_W-1:0]  enableQ
);
  localparam logic [DATA_W-1:0] KEEP_MASK  = DATA_W'(IRQ_KEEP);
  localparam logic [DATA_W-1:0] CARD_RESET =
    (DATA_W'(1) << READY_BIT) | (DATA_W'(1) << CD_BIT);
  localparam int CARD_IRQ [2] = '{CARD0_IRQ, CARD1_IRQ};

  logic [NUM_IRQ-1:0] irqSync;
  logic [DATA_W-1:0]  plainQ  [NUM_PLAIN];
  logic [DATA_W-1:0]  cardQ   [2];
  logic [DATA_W-1:0]  regView [NUM_REGS];

  brdIrqSync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (irqIn),
    .syncOut (irqSync)
  );

  // plain storage registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rstN)                plainQ[g] <= '0;
      else if (strobe.wrHit[g]) plainQ[g] <= wrData;
    end
  end

  // interrupt enable register
  always_ff @(posedge clk) begin
    if (!rstN)                        enableQ <= '0;
    else if (strobe.wrHit[REG_IRQEN]) enableQ <= wrData & KEEP_MASK;
  end

  // sticky status: a software write replaces, otherwise enabled inputs accumulate
  always_ff @(posedge clk) begin
    if (!rstN)                        statusQ <= '0;
    else if (strobe.wrHit[REG_IRQST]) statusQ <= wrData & KEEP_MASK;
    else                              statusQ <= statusQ | (DATA_W'(irqSync) & enableQ);
  end

  // card socket registers: low field writable, detect bit follows its input
  for (genvar c = 0; c < 2; c++) begin : g_card
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cardQ[c] <= CARD_RESET;
      end else begin
        cardQ[c][CD_BIT] <= ~irqSync[CARD_IRQ[c]];
        if (strobe.wrHit[REG_CARD0 + c])
          cardQ[c][CARD_WR_W-1:0] <= wrData[CARD_WR_W-1:0];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PLAIN; i++) regView[i] = plainQ[i];
    regView[REG_IRQEN] = enableQ;
    regView[REG_IRQST] = statusQ;
    regView[REG_CARD0] = cardQ[0];
    regView[REG_CARD1] = cardQ[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdHit) rdData <= regView[strobe.rdIdx];
    else                   rdData <= '0;
  end
endmodule

// File: rtl/brdIrqCtrl.sv
module brdIrqCtrl
  import brdIrqPkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          NUM_IRQ     = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] IRQ_KEEP    = 32'h000F_EEFF,
  parameter int          CARD0_IRQ   = 9,
  parameter int          CARD1_IRQ   = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               hostIrq
);
  busStrobeT          strobe;
  logic [DATA_W-1:0]  statusQ;
  logic [DATA_W-1:0]  enableQ;

  brdIrqCtl #(.ADDR_W(ADDR_W)) u_ctl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  brdIrqDp #(
    .DATA_W      (DATA_W),
    .NUM_IRQ     (NUM_IRQ),
    .SYNC_STAGES (SYNC_STAGES),
    .IRQ_KEEP    (IRQ_KEEP),
    .CARD0_IRQ   (CARD0_IRQ),
    .CARD1_IRQ   (CARD1_IRQ)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .irqIn   (irqIn),
    .rdData  (rdData),
    .statusQ (statusQ),
    .enableQ (enableQ)
  );

  assign hostIrq = |(statusQ & enableQ);
endmodule

// File: rtl/brdIrqChk.sv
module brdIrqChk
  import brdIrqPkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] IRQ_KEEP = 32'h000F_EEFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              hostIrq,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(IRQ_KEEP);

  logic enWr, stWr, mapped;
  assign enWr = wrEn && (addr == ADDR_W'(regOffset(REG_IRQEN)));
  assign stWr = wrEn && (addr == ADDR_W'(regOffset(REG_IRQST)));

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(regOffset(i))) mapped = 1'b1;
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stWr |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R3
  AST_ENABLE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    enWr |=> (enableQ == ($past(wrData) & KEEP_MASK))); // R4
  AST_STATUS_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    stWr |=> (statusQ == ($past(wrData) & KEEP_MASK))); // R5
  AST_IRQ_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && ((wrData & KEEP_MASK) == '0)) |=> !hostIrq); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |-> !hostIrq); // R6
  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0)); // R9
  AST_READ_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == '0)); // R10
endmodule

bind brdIrqCtrl brdIrqChk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IRQ_KEEP (IRQ_KEEP)
) u_chk (.*);

// File: tb/test_brdIrqCtrl.sv
`timescale 1ns/1ps
module test_brdIrqCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] irqIn = '0;
  logic        hostIrq;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  brdIrqCtrl i_brdIrqCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .hostIrq(hostIrq)
  );

  // {offset, write value, expected read-back}
  localparam int NVEC = 13;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h14, 32'h0123_4567, 32'h0123_4567},
    {8'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {8'h60, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {8'h80, 32'h1357_9BDF, 32'h1357_9BDF},
    {8'h84, 32'h8000_0001, 32'h8000_0001},
    {8'h88, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {8'h90, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'hC0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {8'hC0, 32'h0000_0000, 32'h0000_0000},
    {8'hD0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {8'hE0, 32'hFFFF_FFFF, 32'h0000_043F},
    {8'hE4, 32'h0000_0000, 32'h0000_0420}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    d = rdData;
    rdEn = 1'b0; addr = '0;
  endtask

  function automatic string tagOf(input logic [7:0] a);
    case (a)
      8'hC0:        return "R4";
      8'hD0:        return "R5";
      8'hE0, 8'hE4: return "R8";
      default:      return "R2";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    check("R1 hostIrq after reset", {31'd0, hostIrq}, 32'd0);
    busRead(8'hE0, r); check("R1 card0 reset", r, 32'h0000_0420);
    busRead(8'hE4, r); check("R1 card1 reset", r, 32'h0000_0420);
    busRead(8'h10, r); check("R1 led0 reset", r, 32'h0);
    busRead(8'hD0, r); check("R1 status reset", r, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][71:64], VEC[i][63:32]);
      busRead(VEC[i][71:64], r);
      check($sformatf("%s table offset %h", tagOf(VEC[i][71:64]), VEC[i][71:64]), r, VEC[i][31:0]);
    end
    busWrite(8'hD0, 32'h0);

    // R9 idle cycle after a read returns zero
    busRead(8'h10, r);
    @(negedge clk);
    check("R9 rdData idle after read", rdData, 32'h0);

    // R10 unmapped write ignored, unmapped read zero
    busWrite(8'h24, 32'hFFFF_FFFF);
    busRead(8'h24, r); check("R10 unmapped read", r, 32'h0);
    busRead(8'h10, r); check("R10 led0 untouched by unmapped write", r, 32'hDEAD_BEEF);

    // R11 synchronizer latency, R3 latching, R7 card detect
    busWrite(8'hC0, 32'h0000_0200);
    irqIn[9] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 not visible after two edges", {31'd0, hostIrq}, 32'd0);
    @(negedge clk);
    check("R11 visible after third edge", {31'd0, hostIrq}, 32'd1);
    busRead(8'hE0, r); check("R7 card0 detect low while input 9 high", r, 32'h0000_041F);
    irqIn[9] = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 status sticky after input falls", {31'd0, hostIrq}, 32'd1);
    busRead(8'hD0, r); check("R3 status bit 9 held", r, 32'h0000_0200);
    busRead(8'hE0, r); check("R7 card0 detect back high", r, 32'h0000_043F);

    // R5 replace: set bit 0 and clear bit 9 in one write; R6 follow-up
    busWrite(8'hD0, 32'h0000_0001);
    busRead(8'hD0, r); check("R5 status replaced", r, 32'h0000_0001);
    check("R6 hostIrq low, bit 0 not enabled", {31'd0, hostIrq}, 32'd0);
    busWrite(8'hC0, 32'h0000_0001);
    check("R6 hostIrq high right after enable write", {31'd0, hostIrq}, 32'd1);
    busWrite(8'hC0, 32'h0000_0000);
    check("R6 hostIrq low right after disable write", {31'd0, hostIrq}, 32'd0);

    // R4 inputs 8 and 12 never latch; input 13 latches and drives card1
    busWrite(8'hD0, 32'h0);
    busWrite(8'hC0, 32'hFFFF_FFFF);
    irqIn[8] = 1'b1; irqIn[12] = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 masked inputs raise no interrupt", {31'd0, hostIrq}, 32'd0);
    busRead(8'hD0, r); check("R4 masked inputs absent from status", r, 32'h0);
    irqIn[13] = 1'b1;
    repeat (4) @(negedge clk);
    busRead(8'hD0, r); check("R3 input 13 latched", r, 32'h0000_2000);
    busRead(8'hE4, r); check("R7 card1 detect low while input 13 high", r, 32'h0000_0400);

    // R8 only the low field of a card register is writable
    busWrite(8'hE4, 32'hFFFF_FFE0);
    busRead(8'hE4, r); check("R8 upper card bits protected", r, 32'h0000_0400);
    busWrite(8'hE4, 32'h0000_0015);
    busRead(8'hE4, r); check("R8 low card field written", r, 32'h0000_0415);

    irqIn = '0;
    repeat (4) @(negedge clk);
    busRead(8'hE4, r); check("R7 card1 detect high after input 13 falls", r, 32'h0000_0435);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule